// File: doc/BRIEF.md
# Switched-Capacitor Measurement Sequencer

This block sequences a charge-transfer capacitance measurement by steering three tri-state pads. Each pad has an output-enable bit and a data bit. A run begins with a start pulse. The block first drives every pad low to empty both capacitors. It then alternates a charge phase, which fills the small sense capacitor from pad A, with a share phase, which dumps that charge into a large integrating capacitor through pad C. The block counts the completed share phases until an external comparator reports that the integrator has crossed its upper threshold.

An optional calibration phase follows. In it, pads B and C hold low and the integrator drains through a calibration resistor. The block counts tick pulses until the comparator reports that the voltage has fallen below the lower threshold. The block then drives every pad low, holds both counts and raises `done_o`. Software turns the counts into a capacitance. That arithmetic and the analog side are outside this block.

All phase lengths are measured in pulses of `tick_i`, which is a clock enable from a shared time base. The comparator level is resynchronised by two flops before the block uses it.

Top module: `swcap_seq`

## Requirements
- R1: After reset, every pad is driven low (`pad_oe_o`=3'b111, `pad_do_o`=3'b000), both counts are 0, and `done_o` and `timeout_o` are 0. Bit 0 is pad A, bit 1 is pad B and bit 2 is pad C. An enable of 1 means the pad is driven with its data bit.
- R2: A start pulse while the block is idle or finished clears both counts and both flags. The block then drives all three pads low for exactly DISCH_TICKS tick pulses.
- R3: In a charge phase, pad A is driven high and pads B and C are high-impedance (`pad_oe_o`=3'b001, `pad_do_o`=3'b001).
- R4: In a share phase, pad C is driven low and pads A and B are high-impedance (`pad_oe_o`=3'b100, `pad_do_o`=3'b000).
- R5: Every change from charge to share, and from share to charge, passes through exactly one clock cycle with all three pads high-impedance (`pad_oe_o`=3'b000).
- R6: Each full charge phase and each full share phase lasts exactly PHASE_TICKS tick pulses.
- R7: `cycles_o` equals the number of completed share phases at the first clock in which the synchronised comparator is high during charge, share or a gap. It is frozen from then on. A comparator level during discharge has no effect.
- R8: In calibration, pad A is high-impedance and pads B and C are driven low (`pad_oe_o`=3'b110, `pad_do_o`=3'b000). `cal_ticks_o` counts the tick pulses taken while the synchronised comparator stays high. Calibration ends when the comparator goes low.
- R9: In the finished state, `done_o` is 1, all pads are driven low, and both counts hold until the next start, whatever the comparator and tick inputs do.
- R10: A start pulse during a run is ignored. The run does not return to discharge and its counts are unaffected.
- R11: With HAS_CAL=0, a comparator crossing leads directly to the finished state and calibration never appears on the pads.
- R12: If a share phase ends with the cycle counter at its maximum (2^CNT_W-1), the block stops with `done_o`=1, `timeout_o`=1 and `cycles_o` at that maximum. A calibration counter at its maximum on a further tick stops the block in the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse for a measurement run |
| cmp_i | input | 1 | Asynchronous comparator level, high while above threshold |
| tick_i | input | 1 | Time-base enable; one pulse is one phase tick |
| pad_oe_o | output | 3 | Pad output enables, bit 0 = A, bit 1 = B, bit 2 = C |
| pad_do_o | output | 3 | Pad data bits, same bit order |
| cycles_o | output | CNT_W | Completed charge/share cycles at the threshold crossing |
| cal_ticks_o | output | CNT_W | Tick pulses counted during calibration |
| done_o | output | 1 | Run finished, results valid |
| timeout_o | output | 1 | Run stopped on counter saturation |

## Verification
The hardest thing to bring about from the ports is a comparator edge that lands in a known phase after a known number of cycles, once the two-flop delay is counted.

The bench classifies the pad pattern at every falling edge, counts the share-to-gap transitions itself, and raises the comparator a few clocks into a charge phase. That timing leaves the synchroniser delay well inside the phase. For calibration, the bench drops the comparator just after the Nth counted tick. The ticks are four clocks apart, so the next tick arrives after the synchronised level has already gone low.

Saturation needs a narrow second instance with a 4-bit counter. That instance also checks the variant without calibration.

// File: rtl/swcap_pkg.sv
// Shared types for the switched-capacitor sequencer.
// Assumes three pads, indexed A=0, B=1, C=2.
package swcap_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_DISCH, ST_CHARGE, ST_GAP_CS,
        ST_SHARE, ST_GAP_SC, ST_CAL, ST_OUT
    } seq_state_e;

    localparam int PAD_N = 3;
endpackage

// File: rtl/swcap_sync.sv
// Multi-flop level synchroniser for an asynchronous input.
// Assumes STAGES >= 2; the output lags the input by STAGES clocks.
module swcap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_q;

    // shift the input through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], d_i};
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/swcap_tick_timer.sv
// Counts tick pulses within one phase and flags the tick that ends it.
// Assumes limit >= 1; clr restarts the count whenever the phase changes.
module swcap_tick_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         tick_i,
    input  logic [W-1:0] limit_i,
    output logic         last_o
);
    logic [W-1:0] cnt_q;

    assign last_o = tick_i && ((cnt_q + W'(1)) == limit_i);

    // advance on ticks, restart on phase change or expiry
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (clr_i || last_o)  cnt_q <= '0;
        else if (tick_i)           cnt_q <= cnt_q + W'(1);
    end
endmodule

// File: rtl/swcap_pad_map.sv
// Decodes the sequencer state into pad enables and data bits.
// Assumes enable=1 drives the pad with its data bit, 0 leaves it floating.
module swcap_pad_map
    import swcap_pkg::*;
(
    input  seq_state_e       state_i,
    output logic [PAD_N-1:0] oe_o,
    output logic [PAD_N-1:0] do_o
);
    // one drive pattern per state
    always_comb begin
        oe_o = 3'b111;
        do_o = 3'b000;
        unique case (state_i)
            ST_CHARGE:            begin oe_o = 3'b001; do_o = 3'b001; end
            ST_SHARE:             begin oe_o = 3'b100; do_o = 3'b000; end
            ST_GAP_CS, ST_GAP_SC: begin oe_o = 3'b000; do_o = 3'b000; end
            ST_CAL:               begin oe_o = 3'b110; do_o = 3'b000; end
            default:              begin oe_o = 3'b111; do_o = 3'b000; end
        endcase
    end
endmodule

// File: rtl/swcap_seq.sv
// Switched-capacitor measurement sequencer: discharge, charge/share pumping
// until the comparator trips, optional timed calibration, then hold results.
// Assumes tick_i is a single-clock enable and cmp_i may be asynchronous.
module swcap_seq
    import swcap_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int DISCH_TICKS = 8,
    parameter int PHASE_TICKS = 5,
    parameter bit HAS_CAL     = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cmp_i,
    input  logic             tick_i,
    output logic [2:0]       pad_oe_o,
    output logic [2:0]       pad_do_o,
    output logic [CNT_W-1:0] cycles_o,
    output logic [CNT_W-1:0] cal_ticks_o,
    output logic             done_o,
    output logic             timeout_o
);
    localparam int MAXT = (DISCH_TICKS > PHASE_TICKS) ? DISCH_TICKS : PHASE_TICKS;
    localparam int TW   = $clog2(MAXT + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    seq_state_e       state_q, state_d, after_cap;
    logic             cmp_s, ph_last, tmr_clr;
    logic             cyc_inc, cal_inc, to_set, run_clr;
    logic [TW-1:0]    ph_limit;
    logic [CNT_W-1:0] cyc_q, cal_q;
    logic             done_q, to_q;

    swcap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(cmp_i), .q_o(cmp_s)
    );

    assign ph_limit = (state_q == ST_DISCH) ? TW'(DISCH_TICKS) : TW'(PHASE_TICKS);
    assign tmr_clr  = (state_d != state_q);

    swcap_tick_timer #(.W(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr_i(tmr_clr), .tick_i(tick_i),
        .limit_i(ph_limit), .last_o(ph_last)
    );

    swcap_pad_map u_pads (
        .state_i(state_q), .oe_o(pad_oe_o), .do_o(pad_do_o)
    );

    // build option: where the sequence goes after the threshold crossing
    generate
        if (HAS_CAL) begin : g_cal
            assign after_cap = ST_CAL;
        end else begin : g_nocal
            assign after_cap = ST_OUT;
        end
    endgenerate

    // next-state and counter-control decode
    always_comb begin
        state_d = state_q;
        cyc_inc = 1'b0;
        cal_inc = 1'b0;
        to_set  = 1'b0;
        run_clr = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_OUT: begin
                if (start_i) begin
                    state_d = ST_DISCH;
                    run_clr = 1'b1;
                end
            end
            ST_DISCH: begin
                if (ph_last) state_d = ST_CHARGE;
            end
            ST_CHARGE: begin
                if (cmp_s)        state_d = after_cap;
                else if (ph_last) state_d = ST_GAP_CS;
            end
            ST_GAP_CS: begin
                state_d = cmp_s ? after_cap : ST_SHARE;
            end
            ST_SHARE: begin
                if (cmp_s) begin
                    state_d = after_cap;
                end else if (ph_last) begin
                    if (cyc_q == CNT_MAX) begin
                        to_set  = 1'b1;
                        state_d = ST_OUT;
                    end else begin
                        cyc_inc = 1'b1;
                        state_d = ST_GAP_SC;
                    end
                end
            end
            ST_GAP_SC: begin
                state_d = cmp_s ? after_cap : ST_CHARGE;
            end
            ST_CAL: begin
                if (!cmp_s) begin
                    state_d = ST_OUT;
                end else if (tick_i) begin
                    if (cal_q == CNT_MAX) begin
                        to_set  = 1'b1;
                        state_d = ST_OUT;
                    end else begin
                        cal_inc = 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // cycle and calibration counters; they freeze once their phase is left
    always_ff @(posedge clk) begin
        if (!rst_n || run_clr) begin
            cyc_q <= '0;
            cal_q <= '0;
        end else begin
            if (cyc_inc) cyc_q <= cyc_q + CNT_W'(1);
            if (cal_inc) cal_q <= cal_q + CNT_W'(1);
        end
    end

    // completion and saturation flags
    always_ff @(posedge clk) begin
        if (!rst_n || run_clr) begin
            done_q <= 1'b0;
            to_q   <= 1'b0;
        end else begin
            done_q <= (state_d == ST_OUT);
            if (to_set) to_q <= 1'b1;
        end
    end

    assign cycles_o    = cyc_q;
    assign cal_ticks_o = cal_q;
    assign done_o      = done_q;
    assign timeout_o   = to_q;
endmodule

// File: rtl/swcap_seq_chk.sv
// Property checker for the sequencer, attached by bind; observes ports only.
module swcap_seq_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [2:0]       pad_oe_o,
    input logic [2:0]       pad_do_o,
    input logic [CNT_W-1:0] cycles_o,
    input logic [CNT_W-1:0] cal_ticks_o,
    input logic             done_o,
    input logic             timeout_o
);
    logic charging, sharing, all_low;
    assign charging = (pad_oe_o == 3'b001) && (pad_do_o == 3'b001);
    assign sharing  = (pad_oe_o == 3'b100) && (pad_do_o == 3'b000);
    assign all_low  = (pad_oe_o == 3'b111) && (pad_do_o == 3'b000);

    // R5
    gap_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        charging |=> !sharing);
    // R5
    gap_sc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sharing |=> !charging);
    // R9
    done_pads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> all_low);
    // R9
    hold_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> ($stable(cycles_o) && $stable(cal_ticks_o)));
    // R12
    timeout_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> done_o);
    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (charging && start_i) |=> !(all_low && !done_o));
endmodule

bind swcap_seq swcap_seq_chk #(.CNT_W(CNT_W)) u_swcap_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .pad_oe_o(pad_oe_o), .pad_do_o(pad_do_o),
    .cycles_o(cycles_o), .cal_ticks_o(cal_ticks_o),
    .done_o(done_o), .timeout_o(timeout_o)
);

// File: tb/test_swcap_seq.sv
// Directed bench: one task per scenario, each checking its own results.
module test_swcap_seq;
    localparam int CLK_PERIOD = 10;
    localparam int DT = 8;
    localparam int PT = 5;

    localparam int CL_LOW = 0, CL_CHG = 1, CL_SHR = 2, CL_GAP = 3, CL_CAL = 4, CL_OTH = 5;

    logic clk = 0, rst_n = 0, tick = 0;
    logic start_a = 0, cmp_a = 0, start_b = 0, cmp_b = 0;
    logic [2:0] oe_a, do_a, oe_b, do_b;
    logic [15:0] cyc_a, cal_a;
    logic [3:0]  cyc_b, cal_b;
    logic done_a, to_a, done_b, to_b;

    int n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    swcap_seq #(.CNT_W(16), .DISCH_TICKS(DT), .PHASE_TICKS(PT), .HAS_CAL(1'b1)) i_swcap_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_a), .cmp_i(cmp_a), .tick_i(tick),
        .pad_oe_o(oe_a), .pad_do_o(do_a), .cycles_o(cyc_a), .cal_ticks_o(cal_a),
        .done_o(done_a), .timeout_o(to_a));

    swcap_seq #(.CNT_W(4), .DISCH_TICKS(DT), .PHASE_TICKS(PT), .HAS_CAL(1'b0)) i_swcap_seq_nocal (
        .clk(clk), .rst_n(rst_n), .start_i(start_b), .cmp_i(cmp_b), .tick_i(tick),
        .pad_oe_o(oe_b), .pad_do_o(do_b), .cycles_o(cyc_b), .cal_ticks_o(cal_b),
        .done_o(done_b), .timeout_o(to_b));

    // tick every fourth clock, changed just after the rising edge
    int tdiv = 0;
    always @(posedge clk) begin
        #1;
        tdiv = (tdiv + 1) % 4;
        tick = (tdiv == 0);
    end

    function automatic int classify(logic [2:0] oe, logic [2:0] dv);
        if (oe == 3'b111 && dv == 3'b000) return CL_LOW;
        if (oe == 3'b001 && dv == 3'b001) return CL_CHG;
        if (oe == 3'b100 && dv == 3'b000) return CL_SHR;
        if (oe == 3'b000) return CL_GAP;
        if (oe == 3'b110 && dv == 3'b000) return CL_CAL;
        return CL_OTH;
    endfunction

    // pad-pattern monitor for instance A, sampled on falling edges
    logic new_run = 0;
    int cls = CL_LOW, prev_cls = CL_LOW, seg_ticks = 0, gap_len = 0;
    int share_ends = 0, bad_gap = 0, relow = 0, n_other = 0;
    int last_low = 0, last_chg = 0, last_shr = 0;
    bit seen_charge = 0, saw_cal_b = 0, saw_chg_b = 0;
    always @(negedge clk) begin
        cls = classify(oe_a, do_a);
        if (new_run) begin
            seg_ticks = int'(tick); share_ends = 0; bad_gap = 0; relow = 0;
            seen_charge = 0; gap_len = 0; n_other = 0;
        end else if (cls == prev_cls) begin
            seg_ticks += int'(tick);
            if (cls == CL_GAP) gap_len++;
        end else begin
            if (prev_cls == CL_LOW) last_low = seg_ticks;
            if (prev_cls == CL_CHG) last_chg = seg_ticks;
            if (prev_cls == CL_SHR) last_shr = seg_ticks;
            if (prev_cls == CL_SHR && cls == CL_GAP) share_ends++;
            if ((prev_cls == CL_CHG && cls == CL_SHR) || (prev_cls == CL_SHR && cls == CL_CHG)) bad_gap++;
            if (prev_cls == CL_GAP && (cls == CL_CHG || cls == CL_SHR) && gap_len != 1) bad_gap++;
            gap_len = (cls == CL_GAP) ? 1 : 0;
            seg_ticks = int'(tick);
        end
        if (cls == CL_OTH) n_other++;
        if (cls == CL_CHG) seen_charge = 1;
        if (cls == CL_LOW && !done_a && seen_charge) relow++;
        prev_cls = cls;
        if (classify(oe_b, do_b) == CL_CAL) saw_cal_b = 1;
        if (classify(oe_b, do_b) == CL_CHG) saw_chg_b = 1;
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (3) step();
        rst_n = 1;
        step();
        check(oe_a == 3'b111 && do_a == 3'b000, "R1", "pads after reset", int'({oe_a, do_a}), 56);
        check(cyc_a == 0 && cal_a == 0, "R1", "counts after reset", int'(cyc_a) + int'(cal_a), 0);
        check(!done_a && !to_a && !done_b && !to_b, "R1", "flags after reset",
              int'({done_a, to_a, done_b, to_b}), 0);
    endtask

    // full run on instance A: comparator trips after n shares, calibration lasts m ticks
    task automatic t_measure(int n, int m, bit poke);
        start_a = 1; new_run = 1;
        step();
        start_a = 0; new_run = 0;
        while (!(share_ends == n && cls == CL_CHG)) begin
            step();
            if (poke && share_ends == 1 && cls == CL_CHG && !start_a) begin
                start_a = 1; step(); start_a = 0; poke = 0;
            end
        end
        check(last_low == DT, "R2", "discharge ticks", last_low, DT);
        if (n > 0) begin
            check(last_chg == PT, "R6", "charge ticks", last_chg, PT);
            check(last_shr == PT, "R6", "share ticks", last_shr, PT);
            check(bad_gap == 0, "R5", "gap violations", bad_gap, 0);
        end
        check(oe_a == 3'b001 && do_a == 3'b001, "R3", "charge pattern", int'({oe_a, do_a}), 9);
        check(n_other == 0, "R4", "unexpected pad patterns", n_other, 0);
        step(); step();
        cmp_a = 1;
        while (cls != CL_CAL) step();
        check(cyc_a == 16'(n), "R7", "captured cycles", int'(cyc_a), n);
        check(oe_a == 3'b110 && do_a == 3'b000, "R8", "calibration pattern", int'({oe_a, do_a}), 48);
        while (!(cls == CL_CAL && seg_ticks == m)) step();
        cmp_a = 0;
        while (!done_a) step();
        check(cal_a == 16'(m), "R8", "calibration ticks", int'(cal_a), m);
        check(cyc_a == 16'(n), "R7", "cycles at done", int'(cyc_a), n);
        check(!to_a, "R12", "no timeout", int'(to_a), 0);
        check(relow == 0, "R10", "return to discharge during run", relow, 0);
        // results held while inputs wiggle
        repeat (6) begin cmp_a = ~cmp_a; step(); end
        cmp_a = 0;
        repeat (10) step();
        check(cyc_a == 16'(n) && cal_a == 16'(m) && done_a, "R9", "results held",
              int'(cyc_a) * 1000 + int'(cal_a), n * 1000 + m);
        check(oe_a == 3'b111 && do_a == 3'b000, "R9", "pads low when done", int'({oe_a, do_a}), 56);
    endtask

    // instance B: comparator already high in discharge; capture at first charge, no calibration
    task automatic t_nocal();
        saw_cal_b = 0; saw_chg_b = 0;
        start_b = 1; step(); start_b = 0;
        step();
        cmp_b = 1;
        while (!done_b) step();
        check(saw_chg_b, "R7", "discharge ignored comparator", int'(saw_chg_b), 1);
        check(cyc_b == 0, "R7", "capture at first charge", int'(cyc_b), 0);
        check(!saw_cal_b, "R11", "calibration skipped", int'(saw_cal_b), 0);
        check(cal_b == 0 && !to_b, "R11", "no cal count or timeout", int'(cal_b) + int'(to_b), 0);
        cmp_b = 0;
    endtask

    task automatic t_timeout();
        start_b = 1; step(); start_b = 0;
        check(!done_b, "R2", "done cleared by start", int'(done_b), 0);
        while (!done_b) step();
        check(to_b, "R12", "timeout flag", int'(to_b), 1);
        check(cyc_b == 4'hF, "R12", "saturated cycles", int'(cyc_b), 15);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_measure(3, 4, 1'b0);
        t_measure(0, 1, 1'b0);
        t_measure(2, 6, 1'b1);
        t_nocal();
        t_timeout();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule